// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Engine

This block holds the main translation buffer of a memory management unit. The buffer is organised as a number of sets of two or four ways. Software or a miss handler drives it through four registers: a tag word, a data word, an index word and a command strobe.

The tag word carries the virtual page number, an 8-bit address-space identifier and a valid bit. The data word carries the frame number and the permissions, and the engine stores it without looking at its contents. Four commands act on these registers. A probe searches the set selected by the tag word. An allocate picks a slot in that set for a new entry. A write commits both words at the index. A read loads both words from the index. Results come back through the index word, which also reports a missed lookup and a lookup that matched more than one way.

Each command is accepted in the idle state and spends exactly one cycle in an execute state, with `busy` high. It then returns to idle with its results in place. The control FSM has five states. `ST_IDLE` accepts register writes and commands. `ST_PROBE`, `ST_ALLOC`, `ST_COMMIT` and `ST_FETCH` each last one cycle. The transition out of `ST_IDLE` is chosen by the command code, and every execute state returns to `ST_IDLE` unconditionally.

Top module: `tlb_cmd_engine`

## Requirements
- R1: After reset the tag, data and index registers read zero, `busy` is low, and every entry is invalid, so a probe of any tag misses.
- R2: In the idle state a register write with `reg_sel` 0 loads the tag word and `reg_sel` 1 loads the data word. `reg_sel` 2 loads the index word, keeping only bit 31 and the index bits below log2(sets×ways) and clearing all other bits. `reg_sel` 3 changes nothing.
- R3: A command (`cmd_op` 0 probe, 1 allocate, 2 write, 3 read) is accepted only when `busy` is low, and `busy` is then high for exactly one cycle. Commands and register writes presented while `busy` is high are ignored. A register write in the same cycle as an accepted command is dropped.
- R4: A stored entry matches the tag word when its bit 8 (valid) is set, its bits [31:13] equal the tag word's bits [31:13], and its bits [7:0] equal the tag word's bits [7:0]. The set is selected by tag bits [19:13]. On exactly one matching way, a probe loads the index word with set×ways+way and bits 31 and 30 clear.
- R5: A probe with no matching way loads the index word with 0x8000_0000 (bit 31 = lookup failed).
- R6: A probe that matches two or more ways of the set loads the index word with 0xC000_0000 (bits 31 and 30 set).
- R7: Allocate loads the index word with set×ways+way, where way is the lowest-numbered invalid way of the selected set. If every way is valid, the way comes from that set's round-robin pointer, which starts at 0 and advances by one, wrapping, each time it is used.
- R8: Write stores the tag and data words into the entry at the index word's index bits. An all-zero tag word erases the entry. When index bit 31 is set, nothing is stored.
- R9: Read loads the tag and data words from the entry at the index. When index bit 31 is set, both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 tag, 1 data, 2 index, 3 none |
| reg_wdata | input | 32 | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 0 probe, 1 allocate, 2 write, 3 read |
| pd0_q | output | 32 | Tag word register |
| pd1_q | output | 32 | Data word register |
| idx_q | output | 32 | Index word register with error flags |
| busy | output | 1 | High during the execute cycle of a command |

## Verification
The duplicate-match code is the hardest case to reach from the ports. Allocation never places two identical tags in one set on its own, so the bench bypasses it: it writes the index register by hand to two different ways of one set, commits the same tag word to both, and then probes. The round-robin path needs a set with every way filled. Directed stimulus fills one set completely, and a random phase then mixes commands, mid-command register writes and error-flagged indexes over a small pool of tags that shares three sets, so that hits, misses and evictions recur.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int DW      = 32;
    localparam int ERR_BIT = 31;
    localparam int DUP_BIT = 30;

    localparam logic [1:0] SEL_PD0 = 2'd0;
    localparam logic [1:0] SEL_PD1 = 2'd1;
    localparam logic [1:0] SEL_IDX = 2'd2;

    localparam logic [DW-1:0] MISS_CODE = 32'h8000_0000;
    localparam logic [DW-1:0] DUP_CODE  = 32'hC000_0000;

    typedef enum logic [1:0] {
        OP_PROBE  = 2'd0,
        OP_GETIDX = 2'd1,
        OP_WRITE  = 2'd2,
        OP_READ   = 2'd3
    } tlb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PROBE  = 3'd1,
        ST_ALLOC  = 3'd2,
        ST_COMMIT = 3'd3,
        ST_FETCH  = 3'd4
    } tlb_state_e;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    parameter int DW   = 32,
    localparam int ENTRIES = SETS * WAYS,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int SET_W   = $clog2(SETS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DW-1:0]            wr_pd0,
    input  logic [DW-1:0]            wr_pd1,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [DW-1:0]            rd_pd0,
    output logic [DW-1:0]            rd_pd1,
    input  logic [SET_W-1:0]         set_sel,
    output logic [WAYS-1:0][DW-1:0]  set_pd0
);

    logic [DW-1:0] tag_mem  [ENTRIES];
    logic [DW-1:0] data_mem [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_mem[i]  <= '0;
                data_mem[i] <= '0;
            end
        end else if (wr_en) begin
            tag_mem[wr_idx]  <= wr_pd0;
            data_mem[wr_idx] <= wr_pd1;
        end
    end

    assign rd_pd0 = tag_mem[rd_idx];
    assign rd_pd1 = data_mem[rd_idx];

    // column-first layout: all ways of one set sit at consecutive indexes
    for (genvar w = 0; w < WAYS; w++) begin : g_way_rd
        assign set_pd0[w] = tag_mem[IDX_W'(set_sel) * IDX_W'(WAYS) + IDX_W'(w)];
    end

endmodule

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 19,
    parameter int ASID_W = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int CNT_W = $clog2(WAYS + 1)
) (
    input  logic [TAG_W-1:0]             key_tag,
    input  logic [ASID_W-1:0]            key_asid,
    input  logic [WAYS-1:0]              way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
    input  logic [WAYS-1:0][ASID_W-1:0]  way_asid,
    output logic                         any_hit,
    output logic                         multi_hit,
    output logic [WAY_W-1:0]             hit_way
);

    logic [WAYS-1:0] hit_vec;
    logic [CNT_W-1:0] hit_cnt;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w]
                          && (way_tag[w]  == key_tag)
                          && (way_asid[w] == key_asid);
    end

    always_comb begin
        hit_cnt = '0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit_cnt = hit_cnt + 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    assign any_hit   = (hit_cnt != '0);
    assign multi_hit = (hit_cnt > CNT_W'(1));

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  set_sel,
    input  logic [WAYS-1:0]   way_valid,
    input  logic              take,
    output logic [WAY_W-1:0]  victim_way
);

    logic [WAY_W-1:0] rr_ptr [SETS];
    logic             free_found;
    logic [WAY_W-1:0] free_way;

    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
    end

    assign victim_way = free_found ? free_way : rr_ptr[set_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_ptr[s] <= '0;
        end else if (take && !free_found) begin
            if (rr_ptr[set_sel] == WAY_W'(WAYS - 1))
                rr_ptr[set_sel] <= '0;
            else
                rr_ptr[set_sel] <= rr_ptr[set_sel] + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_cmd_engine.sv
module tlb_cmd_engine #(
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int PAGE_SHIFT = 13,
    parameter int ASID_W     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    output logic [31:0] pd0_q,
    output logic [31:0] pd1_q,
    output logic [31:0] idx_q,
    output logic        busy
);
    import tlb_pkg::*;

    localparam int ENTRIES   = SETS * WAYS;
    localparam int IDX_W     = $clog2(ENTRIES);
    localparam int SET_W     = $clog2(SETS);
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W     = DW - PAGE_SHIFT;
    localparam int VALID_BIT = ASID_W;
    localparam logic [DW-1:0] IDX_WMASK =
        (DW'(1) << ERR_BIT) | DW'(ENTRIES - 1);

    tlb_state_e state_q, state_d;

    logic [SET_W-1:0]           set_sel;
    logic [WAYS-1:0][DW-1:0]    set_pd0;
    logic [WAYS-1:0]            way_valid;
    logic [WAYS-1:0][TAG_W-1:0] way_tag;
    logic [WAYS-1:0][ASID_W-1:0] way_asid;
    logic                       any_hit, multi_hit;
    logic [WAY_W-1:0]           hit_way, victim_way;
    logic [DW-1:0]              rd_pd0, rd_pd1;
    logic                       store_we;
    logic [IDX_W-1:0]           cur_idx;

    assign set_sel  = pd0_q[PAGE_SHIFT +: SET_W];
    assign cur_idx  = idx_q[IDX_W-1:0];
    assign store_we = (state_q == ST_COMMIT) && !idx_q[ERR_BIT];
    assign busy     = (state_q != ST_IDLE);

    for (genvar w = 0; w < WAYS; w++) begin : g_split
        assign way_valid[w] = set_pd0[w][VALID_BIT];
        assign way_tag[w]   = set_pd0[w][DW-1:PAGE_SHIFT];
        assign way_asid[w]  = set_pd0[w][ASID_W-1:0];
    end

    tlb_entry_store #(.SETS(SETS), .WAYS(WAYS), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_we),
        .wr_idx  (cur_idx),
        .wr_pd0  (pd0_q),
        .wr_pd1  (pd1_q),
        .rd_idx  (cur_idx),
        .rd_pd0  (rd_pd0),
        .rd_pd1  (rd_pd1),
        .set_sel (set_sel),
        .set_pd0 (set_pd0)
    );

    tlb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_match (
        .key_tag   (pd0_q[DW-1:PAGE_SHIFT]),
        .key_asid  (pd0_q[ASID_W-1:0]),
        .way_valid (way_valid),
        .way_tag   (way_tag),
        .way_asid  (way_asid),
        .any_hit   (any_hit),
        .multi_hit (multi_hit),
        .hit_way   (hit_way)
    );

    tlb_victim_pick #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_sel    (set_sel),
        .way_valid  (way_valid),
        .take       (state_q == ST_ALLOC),
        .victim_way (victim_way)
    );

    function automatic logic [DW-1:0] lin_index(input logic [SET_W-1:0] s,
                                                input logic [WAY_W-1:0] w);
        logic [IDX_W-1:0] li;
        li = IDX_W'(s) * IDX_W'(WAYS) + IDX_W'(w);
        return DW'(li);
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (tlb_op_e'(cmd_op))
                        OP_PROBE:  state_d = ST_PROBE;
                        OP_GETIDX: state_d = ST_ALLOC;
                        OP_WRITE:  state_d = ST_COMMIT;
                        OP_READ:   state_d = ST_FETCH;
                    endcase
                end
            end
            ST_PROBE, ST_ALLOC, ST_COMMIT, ST_FETCH: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // register-side outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd0_q <= '0;
            pd1_q <= '0;
            idx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (reg_we && !cmd_valid) begin
                        if (reg_sel == SEL_PD0) pd0_q <= reg_wdata;
                        if (reg_sel == SEL_PD1) pd1_q <= reg_wdata;
                        if (reg_sel == SEL_IDX) idx_q <= reg_wdata & IDX_WMASK;
                    end
                end
                ST_PROBE: begin
                    if (multi_hit)    idx_q <= DUP_CODE;
                    else if (any_hit) idx_q <= lin_index(set_sel, hit_way);
                    else              idx_q <= MISS_CODE;
                end
                ST_ALLOC: idx_q <= lin_index(set_sel, victim_way);
                ST_FETCH: begin
                    if (!idx_q[ERR_BIT]) begin
                        pd0_q <= rd_pd0;
                        pd1_q <= rd_pd1;
                    end
                end
                ST_COMMIT: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tlb_cmd_engine_chk.sv
module tlb_cmd_engine_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                busy,
    input logic [31:0]         pd1_q,
    input logic [31:0]         idx_q,
    input tlb_pkg::tlb_state_e state_q,
    input logic                multi_hit
);
    import tlb_pkg::*;

    p_busy_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> busy);

    p_dup_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE && multi_hit) |=> (idx_q == DUP_CODE));

    p_dup_has_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q[DUP_BIT] |-> idx_q[ERR_BIT]);

    p_alloc_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALLOC) |=> (idx_q[ERR_BIT:DUP_BIT] == 2'b00));

    p_pd1_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_FETCH) |=> $stable(pd1_q));

endmodule

bind tlb_cmd_engine tlb_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .pd1_q     (pd1_q),
    .idx_q     (idx_q),
    .state_q   (state_q),
    .multi_hit (multi_hit)
);

// File: tb/test_tlb_cmd_engine.sv
module test_tlb_cmd_engine;

    localparam int SETS    = 128;
    localparam int WAYS    = 4;
    localparam int ENTRIES = SETS * WAYS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] pd0_q, pd1_q, idx_q;
    logic        busy;

    always #2ns clk = ~clk;

    tlb_cmd_engine i_tlb_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .pd0_q(pd0_q), .pd1_q(pd1_q), .idx_q(idx_q), .busy(busy)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_e0 [ENTRIES];
    logic [31:0] m_e1 [ENTRIES];
    int          m_rr [SETS];
    logic [31:0] m_pd0, m_pd1, m_idx;
    bit          m_busy;
    logic [1:0]  m_op;

    task automatic model_exec(input logic [1:0] op);
        int s, cnt, loc, w, e;
        s = int'(m_pd0[19:13]);
        case (op)
            2'd0: begin
                cnt = 0; loc = 0;
                for (int k = 0; k < WAYS; k++) begin
                    e = s * WAYS + k;
                    if (m_e0[e][8] && m_e0[e][31:13] == m_pd0[31:13]
                        && m_e0[e][7:0] == m_pd0[7:0]) begin
                        cnt++;
                        if (cnt == 1) loc = e;
                    end
                end
                if (cnt > 1)       m_idx = 32'hC000_0000;
                else if (cnt == 1) m_idx = loc;
                else               m_idx = 32'h8000_0000;
            end
            2'd1: begin
                w = -1;
                for (int k = WAYS - 1; k >= 0; k--)
                    if (!m_e0[s * WAYS + k][8]) w = k;
                if (w < 0) begin
                    w = m_rr[s];
                    m_rr[s] = (m_rr[s] + 1) % WAYS;
                end
                m_idx = s * WAYS + w;
            end
            2'd2: if (!m_idx[31]) begin
                m_e0[m_idx % ENTRIES] = m_pd0;
                m_e1[m_idx % ENTRIES] = m_pd1;
            end
            default: if (!m_idx[31]) begin
                m_pd0 = m_e0[m_idx % ENTRIES];
                m_pd1 = m_e1[m_idx % ENTRIES];
            end
        endcase
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin m_e0[i] = '0; m_e1[i] = '0; end
            for (int s = 0; s < SETS; s++) m_rr[s] = 0;
            m_pd0 = '0; m_pd1 = '0; m_idx = '0; m_busy = 0; m_op = '0;
        end else if (m_busy) begin
            m_busy = 0;
            model_exec(m_op);
        end else if (cmd_valid) begin
            m_busy = 1;
            m_op = cmd_op;
        end else if (reg_we) begin
            case (reg_sel)
                2'd0: m_pd0 = reg_wdata;
                2'd1: m_pd1 = reg_wdata;
                2'd2: m_idx = reg_wdata & (32'h8000_0000 | (ENTRIES - 1));
                default: ;
            endcase
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(cur_req, "busy", {31'd0, busy}, {31'd0, m_busy});
            chk(cur_req, "pd0",  pd0_q, m_pd0);
            chk(cur_req, "pd1",  pd1_q, m_pd1);
            chk(cur_req, "idx",  idx_q, m_idx);
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [31:0] mk(input int vpn, input int asid);
        return (32'(vpn) << 13) | 32'h100 | 32'(asid & 8'hFF);
    endfunction

    task automatic drive(input bit we, input logic [1:0] sel, input logic [31:0] d,
                         input bit cv, input logic [1:0] op);
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = d; cmd_valid = cv; cmd_op = op;
    endtask

    task automatic idle();
        drive(0, 2'd0, '0, 0, 2'd0);
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
        drive(1, sel, d, 0, 2'd0);
        idle();
    endtask

    task automatic cmd(input logic [1:0] op);
        drive(0, 2'd0, '0, 1, op);
        idle();
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        cur_req = "R1";
        chk("R1", "reset pd0", pd0_q, 32'h0);
        chk("R1", "reset idx", idx_q, 32'h0);
        chk("R1", "reset busy", {31'd0, busy}, 32'h0);
        wreg(2'd0, mk(12'h123, 5));
        cmd(2'd0);
        chk("R1", "probe after reset", idx_q, 32'h8000_0000);

        // fill set 3 through allocate
        cur_req = "R7";
        for (int k = 1; k <= 4; k++) begin
            wreg(2'd0, mk((k << 7) | 3, 8'h11));
            cmd(2'd1);
            chk("R7", "first invalid way", idx_q, 32'(3 * WAYS + k - 1));
            wreg(2'd1, 32'h1000 + k);
            cmd(2'd2);
        end
        wreg(2'd0, mk((5 << 7) | 3, 8'h11));
        cmd(2'd1);
        chk("R7", "round robin way 0", idx_q, 32'(3 * WAYS));
        cmd(2'd1);
        chk("R7", "round robin way 1", idx_q, 32'(3 * WAYS + 1));

        cur_req = "R4";
        wreg(2'd0, mk((2 << 7) | 3, 8'h11));
        cmd(2'd0);
        chk("R4", "probe hit index", idx_q, 32'(3 * WAYS + 1));
        cur_req = "R5";
        wreg(2'd0, mk((2 << 7) | 3, 8'h12));
        cmd(2'd0);
        chk("R5", "asid mismatch miss", idx_q, 32'h8000_0000);

        cur_req = "R9";
        wreg(2'd2, 32'(3 * WAYS + 2));
        cmd(2'd3);
        chk("R9", "read pd0", pd0_q, mk((3 << 7) | 3, 8'h11));
        chk("R9", "read pd1", pd1_q, 32'h1003);

        cur_req = "R8";
        wreg(2'd2, 32'(3 * WAYS));
        wreg(2'd0, 32'h0);
        wreg(2'd1, 32'h0);
        cmd(2'd2);
        wreg(2'd0, mk((1 << 7) | 3, 8'h11));
        cmd(2'd0);
        chk("R8", "erased entry misses", idx_q, 32'h8000_0000);

        cur_req = "R6";
        wreg(2'd0, mk((9 << 7) | 5, 8'h22));
        wreg(2'd1, 32'hABCD);
        wreg(2'd2, 32'(5 * WAYS + 2));
        cmd(2'd2);
        wreg(2'd2, 32'(5 * WAYS + 3));
        cmd(2'd2);
        cmd(2'd0);
        chk("R6", "duplicate code", idx_q, 32'hC000_0000);

        cur_req = "R8";
        wreg(2'd2, 32'h8000_0000 | 32'(3 * WAYS + 2));
        wreg(2'd0, mk(77, 1));
        cmd(2'd2);
        wreg(2'd2, 32'(3 * WAYS + 2));
        cmd(2'd3);
        chk("R8", "flagged write stored nothing", pd0_q, mk((3 << 7) | 3, 8'h11));

        cur_req = "R9";
        wreg(2'd0, 32'h5555_0000);
        wreg(2'd2, 32'h8000_0000 | 32'(3 * WAYS + 2));
        cmd(2'd3);
        chk("R9", "flagged read keeps pd0", pd0_q, 32'h5555_0000);

        cur_req = "R2";
        wreg(2'd2, 32'h7FFF_FE05);
        chk("R2", "index mask", idx_q, 32'h0000_0005);
        wreg(2'd3, 32'hFFFF_FFFF);
        chk("R2", "sel 3 ignored pd0", pd0_q, 32'h5555_0000);
        chk("R2", "sel 3 ignored idx", idx_q, 32'h0000_0005);

        cur_req = "R3";
        wreg(2'd1, 32'h0000_0077);
        drive(1, 2'd1, 32'hBAD0, 1, 2'd0);
        drive(1, 2'd1, 32'hBAD1, 1, 2'd3);
        idle();
        chk("R3", "writes around command dropped", pd1_q, 32'h0000_0077);

        // random mix over a small tag pool
        cur_req = "R4";
        for (int i = 0; i < 1200; i++) begin
            int r, sidx;
            logic [31:0] d;
            r = int'($urandom % 10);
            sidx = (r < 5) ? 3 : ((r < 8) ? 5 : 127);
            case ($urandom % 6)
                0, 1: d = mk((int'($urandom % 6) << 7) | sidx, 8'h11 + int'($urandom % 2));
                2:    d = $urandom;
                3:    d = 32'(sidx * WAYS) + 32'($urandom % WAYS);
                4:    d = 32'h8000_0000 | 32'(sidx * WAYS);
                default: d = 32'h0;
            endcase
            drive(bit'($urandom % 2), 2'($urandom), d,
                  bit'(($urandom % 3) == 0), 2'($urandom));
        end
        idle();
        idle();
        cmp_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule